// File: doc/BRIEF.md
# Bus Idle-Time Gate for a Single-Wire Consumer-Control Bus

This block tells a bus transmitter when the shared single-wire line has been quiet long enough for a new message to be started. It measures idle time in half nominal bit periods, driven by a one-cycle `half_tick` strobe. When the programmed quiet interval has elapsed with the line held high, it raises `tx_ready`.

A 3-bit code chooses the interval. Code n from 1 to 7 asks for n − 0.5 bit periods, which is 2n − 1 half ticks. Code 0 falls back to a fixed interval set by the parameter `DEFAULT_BITS`, which defaults to 5 bit periods (10 half ticks).

A mode input selects what starts the measurement:
- With `start_opt` low, software starts it through a start-of-message request.
- With `start_opt` high, it starts automatically at the end of each sent or received message.

Any low level on the line restarts the measurement. The ready flag is then held until the transmitter actually begins sending, or until the line is pulled low.

Top module: `sft_timer`

## Requirements
- R1: While `rst_n` is low, `tx_ready` is 0 and the idle count is cleared. After release, `tx_ready` stays 0 until a start event has been followed by a full interval.
- R2: With `sft_code` = n in 1..7, `tx_ready` rises in the cycle after the (2n−1)-th `half_tick` that arrives with the line high since the start event. Exactly one `half_tick` earlier, it is still 0.
- R3: With `sft_code` = 0, the interval is 2·DEFAULT_BITS half ticks, which is 10 at the default.
- R4: With `start_opt` = 0, a `som_req` pulse starts the measurement. A `msg_end` pulse has no effect: no ready follows it.
- R5: With `start_opt` = 1, a `msg_end` pulse starts the measurement. A `som_req` pulse has no effect.
- R6: A cycle with `line_hi` = 0 during a measurement resets the count to zero. The full interval is then needed again after the line returns high.
- R7: Once raised, `tx_ready` stays 1 while the line is high and no transmission or start event occurs. A low line drops it in the next cycle and restarts the measurement.
- R8: `tx_begin` drops `tx_ready` in the next cycle and stops the measurement. No further ready appears until a new start event.
- R9: A start event during a measurement, or while ready, drops `tx_ready` and restarts the count from zero.
- R10: `tx_ready` rises only in the cycle after a cycle with `half_tick` = 1 and `line_hi` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| half_tick | input | 1 | One-cycle strobe each half nominal bit period |
| line_hi | input | 1 | Synchronised bus line level, 1 = released/high |
| sft_code | input | 3 | Idle interval code, 0 = default interval |
| start_opt | input | 1 | 0 = start on software request, 1 = start on message end |
| som_req | input | 1 | Software start-of-message request pulse |
| msg_end | input | 1 | End of a transmitted or received message pulse |
| tx_begin | input | 1 | Transmitter has started driving a message |
| tx_ready | output | 1 | Line idle long enough; transmission may start |

## Verification
The bench walks every code 1 to 7 and code 0. For each one it checks that ready is still low one half tick before the end of the interval and high just after it. An off-by-one in the 2n−1 mapping, or a default interval of the wrong length, shows up as ready arriving one tick early or late.

It fires the start event that belongs to the other mode and expects nothing to happen. A design with a crossed mode select would raise ready from the wrong event.

A low pulse is inserted in mid-count and again while ready. A design that only paused the count, or that latched ready, would assert too early or hold ready through bus activity. Re-arming mid-count, and sending `tx_begin` followed by a long idle stretch, catch a counter that is not cleared or that keeps re-arming itself.

// File: rtl/sft_pkg.sv
package sft_pkg;

  localparam int unsigned CODE_W    = 3;
  localparam int unsigned NUM_CODES = 1 << CODE_W;

  typedef logic [CODE_W-1:0] sft_code_t;

  // Idle interval in half bit periods: code n -> 2n-1, code 0 -> default
  function automatic int unsigned sft_halves(input int unsigned code,
                                             input int unsigned def_bits);
    if (code == 0) return 2 * def_bits;
    return 2 * code - 1;
  endfunction

endpackage

// File: rtl/sft_target_map.sv
module sft_target_map #(
  parameter int unsigned DEFAULT_BITS = 5,
  parameter int unsigned CW           = 4
) (
  input  sft_pkg::sft_code_t code,
  output logic [CW-1:0]      target
);

  logic [CW-1:0] tbl [sft_pkg::NUM_CODES];

  for (genvar g = 0; g < int'(sft_pkg::NUM_CODES); g++) begin : g_tbl
    assign tbl[g] = CW'(sft_pkg::sft_halves(g, DEFAULT_BITS));
  end

  assign target = tbl[code];

endmodule

// File: rtl/sft_halfbit_counter.sv
module sft_halfbit_counter #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] target,
  output logic [CW-1:0] cnt_q,
  output logic          reached
);

  logic [CW:0]   cnt_plus;
  logic [CW-1:0] cnt_d;

  assign cnt_plus = {1'b0, cnt_q} + {{CW{1'b0}}, 1'b1};
  assign reached  = inc && (cnt_plus >= {1'b0, target});

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_plus[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sft_timer.sv
module sft_timer #(
  parameter int unsigned DEFAULT_BITS = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       half_tick,
  input  logic       line_hi,
  input  logic [2:0] sft_code,
  input  logic       start_opt,
  input  logic       som_req,
  input  logic       msg_end,
  input  logic       tx_begin,
  output logic       tx_ready
);

  localparam int unsigned MAX_HALVES =
    (2 * DEFAULT_BITS > 13) ? 2 * DEFAULT_BITS : 13;
  localparam int unsigned CW = $clog2(MAX_HALVES + 1);

  logic          arm_evt;
  logic          armed_q, armed_d;
  logic          ready_q, ready_d;
  logic          cnt_clr, cnt_inc, reached;
  logic [CW-1:0] target;
  logic [CW-1:0] cnt_q;

  // Start event depends on the selected mode
  assign arm_evt = start_opt ? msg_end : som_req;

  sft_target_map #(.DEFAULT_BITS(DEFAULT_BITS), .CW(CW)) u_map (
    .code   (sft_code),
    .target (target)
  );

  assign cnt_inc = armed_q && !ready_q && line_hi && half_tick &&
                   !arm_evt && !tx_begin;
  assign cnt_clr = arm_evt || tx_begin || !line_hi || reached;

  sft_halfbit_counter #(.CW(CW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (cnt_clr),
    .inc     (cnt_inc),
    .target  (target),
    .cnt_q   (cnt_q),
    .reached (reached)
  );

  // Next-state: start event > transmit start > low line > interval done
  always_comb begin
    armed_d = armed_q;
    ready_d = ready_q;
    if (arm_evt) begin
      armed_d = 1'b1;
      ready_d = 1'b0;
    end else if (tx_begin) begin
      armed_d = 1'b0;
      ready_d = 1'b0;
    end else if (!line_hi) begin
      if (ready_q) begin
        ready_d = 1'b0;
        armed_d = 1'b1;
      end
    end else if (reached) begin
      ready_d = 1'b1;
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      armed_q <= armed_d;
      ready_q <= ready_d;
    end
  end

  assign tx_ready = ready_q;

endmodule

// File: rtl/sft_timer_chk.sv
module sft_timer_chk #(
  parameter int unsigned CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          half_tick,
  input logic          line_hi,
  input logic          start_opt,
  input logic          som_req,
  input logic          msg_end,
  input logic          tx_begin,
  input logic          tx_ready,
  input logic [CW-1:0] cnt_q
);

  logic start_seen;
  assign start_seen = start_opt ? msg_end : som_req;

  assert_rise_after_tick_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ready) |-> $past(half_tick && line_hi));

  assert_low_line_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !line_hi |=> !tx_ready);

  assert_ready_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready && line_hi && !tx_begin && !start_seen) |=> tx_ready);

  assert_txbegin_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_begin |=> !tx_ready);

  assert_start_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_seen |=> (cnt_q == '0 && !tx_ready));

  assert_low_clears_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !line_hi |=> (cnt_q == '0));

endmodule

bind sft_timer sft_timer_chk #(.CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .half_tick (half_tick),
  .line_hi   (line_hi),
  .start_opt (start_opt),
  .som_req   (som_req),
  .msg_end   (msg_end),
  .tx_begin  (tx_begin),
  .tx_ready  (tx_ready),
  .cnt_q     (cnt_q)
);

// File: tb/test_sft_timer.sv
module test_sft_timer;

  localparam int DEF_BITS = 5;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       half_tick, line_hi, start_opt, som_req, msg_end, tx_begin;
  logic [2:0] sft_code;
  logic       tx_ready;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  string cur_req = "R1";

  // behavioural reference state
  bit m_rdy, m_arm;
  int m_cnt;

  sft_timer #(.DEFAULT_BITS(DEF_BITS)) i_sft_timer (
    .clk(clk), .rst_n(rst_n), .half_tick(half_tick), .line_hi(line_hi),
    .sft_code(sft_code), .start_opt(start_opt), .som_req(som_req),
    .msg_end(msg_end), .tx_begin(tx_begin), .tx_ready(tx_ready)
  );

  always #5 clk = ~clk;

  function automatic int halves(input int code);
    return (code == 0) ? 2 * DEF_BITS : 2 * code - 1;
  endfunction

  // reference model, advanced at each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rdy = 0; m_arm = 0; m_cnt = 0;
    end else begin
      bit st;
      st = start_opt ? msg_end : som_req;
      if (st) begin
        m_arm = 1; m_rdy = 0; m_cnt = 0;
      end else if (tx_begin) begin
        m_arm = 0; m_rdy = 0; m_cnt = 0;
      end else if (!line_hi) begin
        m_cnt = 0;
        if (m_rdy) begin m_rdy = 0; m_arm = 1; end
      end else if (m_arm && !m_rdy && half_tick) begin
        m_cnt++;
        if (m_cnt >= halves(int'(sft_code))) begin
          m_rdy = 1; m_arm = 0; m_cnt = 0;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: tx_ready=%0d expected %0d at t=%0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) chk(tx_ready == m_rdy, cur_req, tx_ready, m_rdy);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_bad++;
      $display("FAIL watchdog: cycles=%0d expected <= %0d", cycles, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic cyc(input bit t, input bit l, input bit s, input bit m, input bit b);
    @(negedge clk);
    half_tick = t; line_hi = l; som_req = s; msg_end = m; tx_begin = b;
  endtask

  task automatic tick_n(input int n);
    for (int i = 0; i < n; i++) begin
      cyc(0, 1, 0, 0, 0);
      cyc(1, 1, 0, 0, 0);
    end
  endtask

  task automatic peek(input bit exp, input string req);
    @(negedge clk);
    chk(tx_ready == exp, req, tx_ready, exp);
    half_tick = 0; line_hi = 1; som_req = 0; msg_end = 0; tx_begin = 0;
  endtask

  task automatic arm_now();
    if (start_opt) cyc(0, 1, 0, 1, 0);
    else           cyc(0, 1, 1, 0, 0);
  endtask

  initial begin
    rst_n = 0; half_tick = 0; line_hi = 1; som_req = 0; msg_end = 0;
    tx_begin = 0; sft_code = 3'd1; start_opt = 0;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(tx_ready == 0, "R1", tx_ready, 0);
    @(negedge clk); rst_n = 1;
    tick_n(20);
    peek(0, "R1");

    // R2, R4: every nonzero code with software start
    cur_req = "R2";
    for (int c = 1; c < 8; c++) begin
      sft_code = 3'(c);
      arm_now();
      tick_n(halves(c) - 1);
      peek(0, "R2");
      tick_n(1);
      peek(1, "R2");
      cyc(0, 1, 0, 0, 1);
      peek(0, "R8");
    end

    // R3: default code
    cur_req = "R3";
    sft_code = 3'd0;
    arm_now();
    tick_n(2 * DEF_BITS - 1);
    peek(0, "R3");
    tick_n(1);
    peek(1, "R3");
    cyc(0, 1, 0, 0, 1);

    // R4: message end ignored in software-start mode
    cur_req = "R4";
    sft_code = 3'd2;
    cyc(0, 1, 0, 1, 0);
    tick_n(20);
    peek(0, "R4");

    // R5: automatic start mode, software request ignored
    cur_req = "R5";
    start_opt = 1;
    cyc(0, 1, 1, 0, 0);
    tick_n(20);
    peek(0, "R5");
    arm_now();
    tick_n(2);
    peek(0, "R5");
    tick_n(1);
    peek(1, "R5");
    cyc(0, 1, 0, 0, 1);
    start_opt = 0;

    // R6: low line mid-count restarts
    cur_req = "R6";
    sft_code = 3'd3;
    arm_now();
    tick_n(4);
    cyc(0, 0, 0, 0, 0);
    tick_n(4);
    peek(0, "R6");
    tick_n(1);
    peek(1, "R6");

    // R7: ready holds, then low line drops it and counting restarts
    cur_req = "R7";
    repeat (8) peek(1, "R7");
    cyc(0, 0, 0, 0, 0);
    peek(0, "R7");
    tick_n(4);
    peek(0, "R7");
    tick_n(1);
    peek(1, "R7");

    // R8: transmit start disarms
    cur_req = "R8";
    cyc(0, 1, 0, 0, 1);
    peek(0, "R8");
    tick_n(20);
    peek(0, "R8");

    // R9: re-arm mid-count and while ready
    cur_req = "R9";
    arm_now();
    tick_n(4);
    arm_now();
    tick_n(4);
    peek(0, "R9");
    tick_n(1);
    peek(1, "R9");
    arm_now();
    peek(0, "R9");
    tick_n(5);
    peek(1, "R9");

    // R10: tick with low line never completes the interval
    cur_req = "R10";
    sft_code = 3'd1;
    cyc(0, 1, 0, 0, 1);
    arm_now();
    cyc(1, 0, 0, 0, 0);
    peek(0, "R10");
    cyc(1, 1, 0, 0, 0);
    peek(1, "R10");

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule